// File: doc/BRIEF.md
# GPIO Edge-Detect Interrupt Unit

This unit monitors a wide set of general-purpose input pins, arranged in banks of 32, and turns selected signal transitions into interrupt requests. Each pin can be armed for low-to-high transitions, high-to-low transitions, both, or neither. A transition that matches the pin's arming is recorded in a sticky per-pin status bit. The bit stays set until software clears it by writing a 1 to it.

Pins arrive asynchronously and are resynchronised inside the unit. Pin 0 and pin 1 each have a dedicated interrupt line. Every other pin feeds one combined interrupt line, which stays high while any of those status bits is set. Software uses a small register bus. The address selects a bank (upper bits) and a register within that bank (two low bits). Reads return data one cycle after the address is presented.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, every rise-enable, fall-enable and status register reads 0, and all three interrupt outputs are 0.
- R2: A pin whose rise-enable bit is set and fall-enable bit is clear gets its status bit set by a 0-to-1 transition, and not by a 1-to-0 transition.
- R3: A pin whose fall-enable bit is set and rise-enable bit is clear gets its status bit set by a 1-to-0 transition, and not by a 0-to-1 transition.
- R4: With both enable bits set, either transition sets the status bit. With neither set, no transition sets it.
- R5: A status bit stays set after the pin returns to its earlier level, until software clears it.
- R6: In a status-register write, each 1 bit clears the matching status bit and each 0 bit leaves it unchanged. Writing back a value just read therefore clears exactly the bits that were set.
- R7: Address bits [1:0] select the register: 0 is rise-enable, 1 is fall-enable, 2 is status, and 3 reads as 0. The bits above select the bank. Pin p maps to bit p mod 32 of bank p/32, and banks do not affect one another.
- R8: irq_pin0 equals status bit 0 of bank 0, and irq_pin1 equals status bit 1 of bank 0, each one cycle later. Neither of these bits drives irq_shared.
- R9: irq_shared is 1, one cycle later, whenever any status bit for pin 2 or higher is set.
- R10: If an enabled transition and a write-1 clear reach the same status bit in the same cycle, the bit ends up set.
- R11: Clearing an enable bit leaves an already-set status bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gpio_in | input | 128 | Asynchronous pin levels |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address: bank in [3:2], register in [1:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered one cycle after the address |
| irq_pin0 | output | 1 | Dedicated interrupt for pin 0 |
| irq_pin1 | output | 1 | Dedicated interrupt for pin 1 |
| irq_shared | output | 1 | Combined interrupt for pins 2 and up |

## Verification
Two events can land on the same status bit in the same clock cycle: detection of a new transition, and a software write-1 clear. The bench first sets a pin's status bit. It then reverses the pin and times the clearing write so the write lands exactly when the synchronised transition is detected. Reading the bit back as still set shows that the new transition won; a separate clear with no transition pending must read back 0.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [1:0] {
    REG_RISE = 2'd0,
    REG_FALL = 2'd1,
    REG_STAT = 2'd2,
    REG_NONE = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] meta_q, sync_q, last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      last_q <= '0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign cur  = sync_q;
  assign prev = last_q;
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pins,
  input  logic         wr_rise,
  input  logic         wr_fall,
  input  logic         wr_stat,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rise_en,
  output logic [W-1:0] fall_en,
  output logic [W-1:0] status,
  output logic [W-1:0] edges,
  output logic [W-1:0] clr
);
  logic [W-1:0] cur, prv;

  gpio_pin_sync #(.W(W)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pins),
    .cur      (cur),
    .prev     (prv)
  );

  assign edges = (rise_en & cur & ~prv) | (fall_en & ~cur & prv);
  assign clr   = wr_stat ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_en <= '0;
      fall_en <= '0;
      status  <= '0;
    end else begin
      if (wr_rise) rise_en <= wdata;
      if (wr_fall) fall_en <= wdata;
      status <= (status & ~clr) | edges;
    end
  end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_irq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 32,
  parameter int ADDR_W    = $clog2(NUM_BANKS) + 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_BANKS*BANK_W-1:0] gpio_in,
  input  logic                        bus_we,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [BANK_W-1:0]           bus_wdata,
  output logic [BANK_W-1:0]           bus_rdata,
  output logic                        irq_pin0,
  output logic                        irq_pin1,
  output logic                        irq_shared
);
  localparam int TOTAL  = NUM_BANKS * BANK_W;
  localparam int BSEL_W = ADDR_W - 2;

  logic [BSEL_W-1:0] bank_sel;
  reg_kind_e         kind;
  logic [BANK_W-1:0] rise_b [NUM_BANKS];
  logic [BANK_W-1:0] fall_b [NUM_BANKS];
  logic [BANK_W-1:0] stat_b [NUM_BANKS];
  logic [TOTAL-1:0]  stat_all, edge_all, clr_all;
  logic [BANK_W-1:0] rd_mux;

  assign bank_sel = bus_addr[ADDR_W-1:2];
  assign kind     = reg_kind_e'(bus_addr[1:0]);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = bus_we && (bank_sel == BSEL_W'(b));

    gpio_edge_bank #(.W(BANK_W)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .pins    (gpio_in[b*BANK_W +: BANK_W]),
      .wr_rise (hit && (kind == REG_RISE)),
      .wr_fall (hit && (kind == REG_FALL)),
      .wr_stat (hit && (kind == REG_STAT)),
      .wdata   (bus_wdata),
      .rise_en (rise_b[b]),
      .fall_en (fall_b[b]),
      .status  (stat_b[b]),
      .edges   (edge_all[b*BANK_W +: BANK_W]),
      .clr     (clr_all[b*BANK_W +: BANK_W])
    );

    assign stat_all[b*BANK_W +: BANK_W] = stat_b[b];
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_sel == BSEL_W'(b)) begin
        case (kind)
          REG_RISE: rd_mux = rise_b[b];
          REG_FALL: rd_mux = fall_b[b];
          REG_STAT: rd_mux = stat_b[b];
          default:  rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      irq_pin0   <= 1'b0;
      irq_pin1   <= 1'b0;
      irq_shared <= 1'b0;
    end else begin
      bus_rdata  <= rd_mux;
      irq_pin0   <= stat_all[0];
      irq_pin1   <= stat_all[1];
      irq_shared <= |stat_all[TOTAL-1:2];
    end
  end
endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
  parameter int TOTAL = 128
) (
  input logic             clk,
  input logic             rst,
  input logic [TOTAL-1:0] stat_all,
  input logic [TOTAL-1:0] edge_all,
  input logic [TOTAL-1:0] clr_all,
  input logic             irq_pin0,
  input logic             irq_pin1,
  input logic             irq_shared
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (stat_all == '0 && !irq_pin0 && !irq_pin1 && !irq_shared));

  assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((($past(stat_all) & ~$past(clr_all)) & ~stat_all)) == '0));

  assert_w1c_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((($past(clr_all) & ~$past(edge_all)) & stat_all)) == '0));

  assert_edge_wins_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(edge_all) & ~stat_all) == '0));

  assert_pin_lines_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_pin0 == $past(stat_all[0]) && irq_pin1 == $past(stat_all[1])));

  assert_shared_line_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_shared == $past(|stat_all[TOTAL-1:2])));
endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(.TOTAL(TOTAL)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .stat_all   (stat_all),
  .edge_all   (edge_all),
  .clr_all    (clr_all),
  .irq_pin0   (irq_pin0),
  .irq_pin1   (irq_pin1),
  .irq_shared (irq_shared)
);

// File: tb/test_gpio_edge_irq.sv
module test_gpio_edge_irq;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [127:0] gpio_in = '0;
  logic         bus_we = 1'b0;
  logic [3:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         irq_pin0, irq_pin1, irq_shared;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        rd_issue = 1'b0;
  logic        mon_due = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_edge_irq i_gpio_edge_irq (
    .clk        (clk),
    .rst        (rst),
    .gpio_in    (gpio_in),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .irq_pin0   (irq_pin0),
    .irq_pin1   (irq_pin1),
    .irq_shared (irq_shared)
  );

  function automatic logic [3:0] ra(input int bank, input int kind);
    return {2'(bank), 2'(kind)};
  endfunction

  // Monitor: pops the expected read value one cycle after each read is issued.
  always @(posedge clk) mon_due <= rd_issue;

  always @(negedge clk) begin
    if (mon_due) begin
      logic [31:0] e;
      string t;
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL scoreboard empty: actual=%h expected=none", bus_rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          bad++;
          $display("FAIL %s: actual=%h expected=%h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_exp(input logic [3:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_issue = 1'b1;
    @(negedge clk);
    rd_issue = 1'b0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic chk_irq(input logic [2:0] e, input string t);
    @(negedge clk);
    total++;
    if ({irq_pin0, irq_pin1, irq_shared} !== e) begin
      bad++;
      $display("FAIL %s: actual irq=%b expected=%b", t,
               {irq_pin0, irq_pin1, irq_shared}, e);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd_exp(ra(0,0), 32'h0, "R1 rise reset");
    rd_exp(ra(0,1), 32'h0, "R1 fall reset");
    rd_exp(ra(0,2), 32'h0, "R1 status reset");
    rd_exp(ra(3,2), 32'h0, "R1 bank3 status reset");
    chk_irq(3'b000, "R1 irq reset");

    // R2 rise-only on pin 5
    wr(ra(0,0), 32'h20);
    gpio_in[5] = 1'b1; settle();
    rd_exp(ra(0,2), 32'h20, "R2 rise sets");
    chk_irq(3'b001, "R9 shared from pin5");
    gpio_in[5] = 1'b0; settle();
    rd_exp(ra(0,2), 32'h20, "R5 sticky after pin returns");
    wr(ra(0,2), 32'h20); settle();
    rd_exp(ra(0,2), 32'h0, "R6 write-1 clears");
    chk_irq(3'b000, "R9 shared drops");
    gpio_in[5] = 1'b1; settle();
    wr(ra(0,2), 32'h20);
    gpio_in[5] = 1'b0; settle();
    rd_exp(ra(0,2), 32'h0, "R2 fall ignored");

    // R11 enable cleared keeps status
    gpio_in[5] = 1'b1; settle();
    wr(ra(0,0), 32'h0); settle();
    rd_exp(ra(0,0), 32'h0, "R11 enable cleared");
    rd_exp(ra(0,2), 32'h20, "R11 status kept");
    wr(ra(0,2), 32'h20);

    // R3 fall-only on pin 40 (bank1 bit8)
    wr(ra(1,1), 32'h100);
    gpio_in[40] = 1'b1; settle();
    rd_exp(ra(1,2), 32'h0, "R3 rise ignored");
    gpio_in[40] = 1'b0; settle();
    rd_exp(ra(1,2), 32'h100, "R3 fall sets");
    chk_irq(3'b001, "R9 shared from pin40");
    wr(ra(1,2), 32'h0);
    rd_exp(ra(1,2), 32'h100, "R6 write-0 no effect");
    wr(ra(1,2), 32'h100);
    rd_exp(ra(1,2), 32'h0, "R6 write-back clears");

    // R4 both on pin 70, neither on pin 71 (bank2 bits 6,7)
    wr(ra(2,0), 32'h40);
    wr(ra(2,1), 32'h40);
    gpio_in[71:70] = 2'b11; settle();
    rd_exp(ra(2,2), 32'h40, "R4 both: rise sets, neither stays 0");
    wr(ra(2,2), 32'h40);
    gpio_in[71:70] = 2'b00; settle();
    rd_exp(ra(2,2), 32'h40, "R4 both: fall sets, neither stays 0");
    wr(ra(2,2), 32'h40);

    // R7 bank mapping with pin 127
    wr(ra(3,0), 32'h8000_0000);
    gpio_in[127] = 1'b1; settle();
    rd_exp(ra(3,2), 32'h8000_0000, "R7 pin127 in bank3 bit31");
    rd_exp(ra(0,2), 32'h0, "R7 bank0 untouched");
    rd_exp(ra(2,2), 32'h0, "R7 bank2 untouched");
    rd_exp(ra(3,0), 32'h8000_0000, "R7 rise enable readback");
    rd_exp(ra(3,3), 32'h0, "R7 unused register reads 0");
    wr(ra(3,2), 32'h8000_0000); settle();

    // R8 dedicated lines
    wr(ra(0,0), 32'h3);
    gpio_in[0] = 1'b1; settle();
    chk_irq(3'b100, "R8 pin0 line only");
    gpio_in[1] = 1'b1; settle();
    chk_irq(3'b110, "R8 pin1 line, shared low");
    rd_exp(ra(0,2), 32'h3, "R8 status bits 0,1");
    wr(ra(0,2), 32'h1); settle();
    chk_irq(3'b010, "R8 pin0 cleared");
    wr(ra(0,2), 32'h2); settle();
    chk_irq(3'b000, "R8 pin1 cleared");

    // R10 edge and clear in the same cycle
    wr(ra(0,0), 32'h20);
    wr(ra(0,1), 32'h20);
    gpio_in[5] = 1'b0; settle();
    wr(ra(0,2), 32'h20);
    gpio_in[5] = 1'b1; settle();
    rd_exp(ra(0,2), 32'h20, "R10 setup bit set");
    @(negedge clk);
    gpio_in[5] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = ra(0,2); bus_wdata = 32'h20;
    @(negedge clk);
    bus_we = 1'b0;
    settle();
    rd_exp(ra(0,2), 32'h20, "R10 edge wins over clear");
    wr(ra(0,2), 32'h20); settle();
    rd_exp(ra(0,2), 32'h0, "R10 lone clear works");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      total++;
      bad++;
      $display("FAIL scoreboard leftover: actual=%0d expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule